// File: doc/BRIEF.md
# Burst and Deep-Burst Mode Controller

This block is the digital mode sequencer of a flyback PWM controller. It receives synchronous flags from external comparators on the feedback node and the supply rail, a strobe for every gate pulse, a gap-detect strobe and a free-running millisecond tick. From these it decides whether switching is allowed and whether the converter runs in ordinary burst operation or in the low-power deep-burst operation.

In ordinary burst the converter stops switching when feedback drops under the lower threshold (2.0 V) and restarts above the upper one (2.1 V). When three idle intervals in a row each last at least the long-idle time, the controller starts a qualification delay. If the delay runs out without a long unbroken run of gate pulses, it enters deep burst. There `deep_mode` tells the comparators to use the raised threshold pair (2.55 V stop, 2.7 V restart). While idle in deep burst, the controller requests feedback impedance modulation whenever the supply falls to the modulation level. Deep burst is left after a long run of pulses, or at once when feedback recovers while the supply is still above the modulation level.

States: `ST_NORM_RUN`, `ST_NORM_IDLE`, `ST_QUAL_RUN`, `ST_QUAL_IDLE`, `ST_DEEP_RUN`, `ST_DEEP_IDLE`.

Transitions:
- **stop**: any RUN state goes to its IDLE state on `fb_stop`.
- **restart**: an IDLE state goes to its RUN state on `fb_restart`.
- **qualify**: `ST_NORM_IDLE` goes to `ST_QUAL_RUN` when the third consecutive long interval ends.
- **enter**: a QUAL state goes to the matching DEEP state when the delay completes.
- **veto**: a QUAL state goes to the matching NORM state on a pulse run.
- **pulse-exit**: `ST_DEEP_RUN` goes to `ST_NORM_RUN` on a pulse run.
- **recover-exit**: `ST_DEEP_IDLE` goes to `ST_NORM_IDLE`.

Top module: `burst_mode_ctrl`

## Requirements
- R1: A synchronous active-low reset puts the block in `ST_NORM_RUN`: `sw_en`=1, `deep_mode`=0 and `zfb_req`=0. It also clears the long-interval count and all timers and run counters.
- R2: Outside deep burst, `fb_stop` while switching clears `sw_en` on the next clock. `fb_restart` while idle sets it on the next clock. Without either flag, `sw_en` holds.
- R3: An idle interval counts as long when at least LONG_IDLE_TICKS ticks (default 8) arrive between the stop and the restart. An interval with fewer ticks clears the count of consecutive long intervals. The end of the LONG_RUNS-th (default 3) consecutive long interval starts qualification.
- R4: During qualification, burst switching continues on the normal thresholds. `deep_mode` rises one clock after the QUAL_TICKS-th tick (default 600) of the delay has been counted.
- R5: During qualification, a run of more than PULSE_LIMIT (default 112) consecutive `gate_pulse` strobes cancels entry. The block returns to normal burst, and a fresh sequence of long intervals is needed.
- R6: `gap_det` ends a pulse run. A pulse that arrives together with `gap_det` counts as the first pulse of a new run.
- R7: In `ST_DEEP_RUN`, the pulse run counter restarts when deep burst is entered. The clock after the (PULSE_LIMIT+1)-th pulse of a run returns the block to `ST_NORM_RUN` with `deep_mode`=0.
- R8: In deep burst, stop and restart behave as in R2. `zfb_req` is 1 exactly while in `ST_DEEP_IDLE` with `vdd_low`=1, and is 0 in every other state.
- R9: In `ST_DEEP_IDLE`, `fb_recover`=1 with `vdd_low`=0 leaves deep burst on the next clock into `ST_NORM_IDLE`, with `sw_en`=0. This exit takes priority over `fb_restart` in the same cycle. With `vdd_low`=1 the block stays in deep burst.
- R10: When the qualification delay completes in the same cycle that a pulse run exceeds PULSE_LIMIT, the veto wins and deep burst is not entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fb_stop | input | 1 | Feedback is below the stop threshold of the selected pair |
| fb_restart | input | 1 | Feedback is above the restart threshold of the selected pair |
| fb_recover | input | 1 | Feedback is above the recovery level (0.9 V) |
| vdd_low | input | 1 | Supply is at or below the modulation level |
| gate_pulse | input | 1 | One-cycle strobe per gate pulse |
| gap_det | input | 1 | Idle gap longer than one switching period |
| ms_tick | input | 1 | One-cycle strobe per millisecond |
| sw_en | output | 1 | Switching is allowed |
| deep_mode | output | 1 | Deep burst is active; selects the raised threshold pair |
| zfb_req | output | 1 | Request for feedback impedance modulation |

## Verification
Two pairs of events can fall in the same clock.

The first pair is qualification completion and the pulse-run veto. The bench provokes it by counting 599 delay ticks, then 112 pulses, then one cycle that carries both the 600th tick and the 113th pulse. The bench then expects to stay in normal burst, and still in normal burst long after the delay would have ended.

The second pair is the deep-idle restart and the recovery exit. The bench raises `fb_restart` and `fb_recover` together, with the supply above the modulation level. It expects the exit: `sw_en`=0 and `deep_mode`=0, not a deep restart.

// File: rtl/burst_mode_pkg.sv
package burst_mode_pkg;
    typedef enum logic [2:0] {
        ST_NORM_RUN,
        ST_NORM_IDLE,
        ST_QUAL_RUN,
        ST_QUAL_IDLE,
        ST_DEEP_RUN,
        ST_DEEP_IDLE
    } mode_state_t;
endpackage

// File: rtl/burst_sat_counter.sv
// Saturating event counter: flags once LIMIT events have been counted.
module burst_sat_counter #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic reached
);
    localparam int unsigned W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            // an event coincident with a clear starts the new count
            cnt <= inc ? W'(1) : '0;
        end else if (inc && !reached) begin
            cnt <= cnt + W'(1);
        end
    end

    assign reached = (cnt >= W'(LIMIT));
endmodule

// File: rtl/burst_mode_fsm.sv
module burst_mode_fsm
    import burst_mode_pkg::*;
#(
    parameter int unsigned LONG_RUNS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fb_stop,
    input  logic fb_restart,
    input  logic fb_recover,
    input  logic vdd_low,
    input  logic idle_long,
    input  logic qual_done,
    input  logic pulse_veto,
    output logic sw_en,
    output logic deep_mode,
    output logic zfb_req,
    output logic in_norm_idle,
    output logic qualifying,
    output logic pulse_clr
);
    localparam int unsigned LW = $clog2(LONG_RUNS + 1);

    mode_state_t state, nxt;
    logic [LW-1:0] long_cnt, long_nxt;

    // next-state logic
    always_comb begin
        nxt       = state;
        long_nxt  = long_cnt;
        pulse_clr = 1'b0;
        unique case (state)
            ST_NORM_RUN: begin
                if (fb_stop) nxt = ST_NORM_IDLE;
            end
            ST_NORM_IDLE: begin
                if (fb_restart) begin
                    nxt = ST_NORM_RUN;
                    if (!idle_long) begin
                        long_nxt = '0;
                    end else if (long_cnt == LW'(LONG_RUNS - 1)) begin
                        nxt       = ST_QUAL_RUN;
                        long_nxt  = '0;
                        pulse_clr = 1'b1;
                    end else begin
                        long_nxt = long_cnt + LW'(1);
                    end
                end
            end
            ST_QUAL_RUN: begin
                if (pulse_veto) begin
                    nxt = ST_NORM_RUN;
                end else if (qual_done) begin
                    nxt       = ST_DEEP_RUN;
                    pulse_clr = 1'b1;
                end else if (fb_stop) begin
                    nxt = ST_QUAL_IDLE;
                end
            end
            ST_QUAL_IDLE: begin
                if (pulse_veto) begin
                    nxt = ST_NORM_IDLE;
                end else if (qual_done) begin
                    nxt       = ST_DEEP_IDLE;
                    pulse_clr = 1'b1;
                end else if (fb_restart) begin
                    nxt = ST_QUAL_RUN;
                end
            end
            ST_DEEP_RUN: begin
                if (pulse_veto) nxt = ST_NORM_RUN;
                else if (fb_stop) nxt = ST_DEEP_IDLE;
            end
            ST_DEEP_IDLE: begin
                if (fb_recover && !vdd_low) nxt = ST_NORM_IDLE;
                else if (fb_restart) nxt = ST_DEEP_RUN;
            end
            default: nxt = ST_NORM_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_NORM_RUN;
            long_cnt <= '0;
        end else begin
            state    <= nxt;
            long_cnt <= long_nxt;
        end
    end

    // outputs
    always_comb begin
        sw_en        = (state == ST_NORM_RUN) || (state == ST_QUAL_RUN) ||
                       (state == ST_DEEP_RUN);
        deep_mode    = (state == ST_DEEP_RUN) || (state == ST_DEEP_IDLE);
        zfb_req      = (state == ST_DEEP_IDLE) && vdd_low;
        in_norm_idle = (state == ST_NORM_IDLE);
        qualifying   = (state == ST_QUAL_RUN) || (state == ST_QUAL_IDLE);
    end
endmodule

// File: rtl/burst_mode_ctrl.sv
module burst_mode_ctrl #(
    parameter int unsigned LONG_IDLE_TICKS = 8,
    parameter int unsigned LONG_RUNS       = 3,
    parameter int unsigned QUAL_TICKS      = 600,
    parameter int unsigned PULSE_LIMIT     = 112
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fb_stop,
    input  logic fb_restart,
    input  logic fb_recover,
    input  logic vdd_low,
    input  logic gate_pulse,
    input  logic gap_det,
    input  logic ms_tick,
    output logic sw_en,
    output logic deep_mode,
    output logic zfb_req
);
    localparam int unsigned RUN_MAX = PULSE_LIMIT + 1;

    logic idle_long, qual_done, pulse_veto;
    logic in_norm_idle, qualifying, pulse_clr;

    burst_sat_counter #(.LIMIT(LONG_IDLE_TICKS)) u_idle_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!in_norm_idle),
        .inc    (ms_tick && in_norm_idle),
        .reached(idle_long)
    );

    burst_sat_counter #(.LIMIT(QUAL_TICKS)) u_qual_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!qualifying),
        .inc    (ms_tick && qualifying),
        .reached(qual_done)
    );

    burst_sat_counter #(.LIMIT(RUN_MAX)) u_run_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (gap_det || pulse_clr),
        .inc    (gate_pulse),
        .reached(pulse_veto)
    );

    burst_mode_fsm #(.LONG_RUNS(LONG_RUNS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .fb_stop     (fb_stop),
        .fb_restart  (fb_restart),
        .fb_recover  (fb_recover),
        .vdd_low     (vdd_low),
        .idle_long   (idle_long),
        .qual_done   (qual_done),
        .pulse_veto  (pulse_veto),
        .sw_en       (sw_en),
        .deep_mode   (deep_mode),
        .zfb_req     (zfb_req),
        .in_norm_idle(in_norm_idle),
        .qualifying  (qualifying),
        .pulse_clr   (pulse_clr)
    );
endmodule

// File: rtl/burst_mode_ctrl_chk.sv
module burst_mode_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic fb_stop,
    input logic fb_restart,
    input logic fb_recover,
    input logic vdd_low,
    input logic sw_en,
    input logic deep_mode,
    input logic zfb_req,
    input logic qual_done,
    input logic pulse_veto
);
    // R8
    zfb_only_deep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zfb_req |-> (deep_mode && !sw_en && vdd_low));

    // R2
    sw_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_en) |-> $past(fb_stop));

    // R2
    sw_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_en) |-> $past(fb_restart));

    // R4
    deep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(deep_mode) |-> $past(qual_done));

    // R7
    pulse_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(deep_mode) && sw_en) |-> $past(pulse_veto));

    // R9
    recover_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(deep_mode) && !sw_en) |-> $past(fb_recover && !vdd_low));
endmodule

bind burst_mode_ctrl burst_mode_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fb_stop   (fb_stop),
    .fb_restart(fb_restart),
    .fb_recover(fb_recover),
    .vdd_low   (vdd_low),
    .sw_en     (sw_en),
    .deep_mode (deep_mode),
    .zfb_req   (zfb_req),
    .qual_done (qual_done),
    .pulse_veto(pulse_veto)
);

// File: tb/burst_mode_ctrl_tb.sv
`timescale 1ns/1ps
module burst_mode_ctrl_tb;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic fb_stop = 0, fb_restart = 0, fb_recover = 0, vdd_low = 0;
    logic gate_pulse = 0, gap_det = 0, ms_tick = 0;
    logic sw_en, deep_mode, zfb_req;

    int n_chk = 0;
    int n_fail = 0;

    burst_mode_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .fb_stop(fb_stop), .fb_restart(fb_restart),
        .fb_recover(fb_recover), .vdd_low(vdd_low), .gate_pulse(gate_pulse),
        .gap_det(gap_det), .ms_tick(ms_tick), .sw_en(sw_en),
        .deep_mode(deep_mode), .zfb_req(zfb_req)
    );

    // vector: {stop, restart, recover, vdd_low, pulse, gap, tick, exp_sw, exp_deep, exp_zfb}
    localparam logic [9:0] VEC [8] = '{
        10'b0000000_100,  // R2 idle input, keep switching
        10'b1000000_000,  // R2 stop
        10'b0000000_000,  // R2 hold idle
        10'b0100000_100,  // R2 restart
        10'b1001000_000,  // R8 vdd low outside deep: no modulation
        10'b0100000_100,  // R2 restart after short idle
        10'b0010000_100,  // R9 recover ignored outside deep
        10'b0000100_100   // R2 pulse while running
    };

    task automatic cyc(input logic lo, hi, rec, vl, pl, gp, tk);
        @(negedge clk);
        fb_stop = lo; fb_restart = hi; fb_recover = rec; vdd_low = vl;
        gate_pulse = pl; gap_det = gp; ms_tick = tk;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [2:0] exp);
        n_chk++;
        if ({sw_en, deep_mode, zfb_req} !== exp) begin
            n_fail++;
            $display("FAIL %s: {sw_en,deep_mode,zfb_req} actual %b expected %b",
                     req, {sw_en, deep_mode, zfb_req}, exp);
        end
    endtask

    task automatic idle_cyc();
        cyc(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 1);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 1, 0, 0);
    endtask

    task automatic long_idle(input int n);
        cyc(1, 0, 0, 0, 0, 0, 0);
        ticks(n);
        cyc(0, 1, 0, 0, 0, 0, 0);
    endtask

    task automatic enter_qual();
        for (int i = 0; i < 3; i++) long_idle(8);
    endtask

    task automatic enter_deep();
        enter_qual();
        ticks(600);
        idle_cyc();
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        #800000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        repeat (2) idle_cyc();
        check("R1 reset state", 3'b100);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < 8; i++) begin
            cyc(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3]);
            check($sformatf("R2 table row %0d", i), VEC[i][2:0]);
        end

        // R3: a short interval breaks the run of long intervals
        long_idle(8); long_idle(8); long_idle(7); long_idle(8); long_idle(8);
        ticks(610); idle_cyc();
        check("R3 short interval resets count", 3'b100);
        // third consecutive long interval -> qualification, R4 timing
        long_idle(8);
        ticks(599); idle_cyc();
        check("R4 before delay end", 3'b100);
        ticks(1);
        check("R4 last delay tick", 3'b100);
        idle_cyc();
        check("R4 deep entry", 3'b110);

        // R7: pulse run exit
        pulses(113);
        check("R7 still deep at 113th pulse", 3'b110);
        idle_cyc();
        check("R7 pulse exit", 3'b100);

        // R5: veto during qualification
        enter_qual();
        pulses(113); idle_cyc();
        ticks(610); idle_cyc();
        check("R5 veto cancels entry", 3'b100);

        // R6: gap restarts the run, 112+112 pulses do not veto
        enter_qual();
        pulses(112);
        cyc(0, 0, 0, 0, 1, 1, 0);
        pulses(111);
        ticks(610); idle_cyc();
        check("R6 gap restarts pulse run", 3'b110);

        // R8 / R9 in deep burst
        cyc(1, 0, 0, 0, 0, 0, 0);
        check("R8 deep stop", 3'b010);
        cyc(0, 0, 0, 1, 0, 0, 0);
        check("R8 modulation request", 3'b011);
        cyc(0, 0, 1, 1, 0, 0, 0);
        check("R9 no exit while vdd low", 3'b011);
        idle_cyc();
        check("R8 modulation released", 3'b010);
        cyc(0, 1, 0, 1, 0, 0, 0);
        check("R8 deep restart", 3'b110);
        cyc(1, 0, 0, 0, 0, 0, 0);
        check("R8 deep stop again", 3'b010);
        cyc(0, 1, 1, 0, 0, 0, 0);
        check("R9 recover exit beats restart", 3'b000);
        cyc(0, 1, 0, 0, 0, 0, 0);
        check("R9 normal restart after exit", 3'b100);

        // R10: veto and delay completion in the same cycle
        enter_qual();
        ticks(599);
        pulses(112);
        cyc(0, 0, 0, 0, 1, 0, 1);
        idle_cyc();
        check("R10 veto wins same cycle", 3'b100);
        ticks(610); idle_cyc();
        check("R10 stays normal", 3'b100);

        // R1: reset from deep idle and clearing of the long count
        enter_deep();
        cyc(1, 0, 0, 1, 0, 0, 0);
        check("R1 precondition deep idle", 3'b011);
        @(negedge clk) rst_n = 1'b0;
        idle_cyc();
        @(negedge clk) rst_n = 1'b1;
        check("R1 reset from deep", 3'b100);
        long_idle(8); long_idle(8);
        @(negedge clk) rst_n = 1'b0;
        idle_cyc();
        @(negedge clk) rst_n = 1'b1;
        long_idle(8);
        ticks(610); idle_cyc();
        check("R1 long count cleared", 3'b100);

        summary();
        $finish;
    end
endmodule